// File: doc/BRIEF.md
# Tile Address Window Protection Unit

This block sits between one processor tile's bus and the path that leads to shared main memory and to the tile's own peripherals. It decodes each request address into one of three windows. The private window is the same local address range on every tile. Accesses there are relocated to the segment of main memory that belongs to this tile, so code and data structures keep working when a thread moves to another tile. The global window is a read-only view of every tile's segment, which lets a tile read a sibling's state for comparison or resynchronisation. The peripheral window decodes to a fixed local offset that does not depend on the tile.

Writes into the global window are refused, answered with an error code and recorded in a violation register. Addresses outside every window are refused with a decode error and reach neither memory nor peripherals. A tile number is captured while reset is held and fixes the relocation for the rest of the run. The memory controller reports ECC errors to this block. These errors go to a supervisor output together with the physical address of the access, and the tile's own response stays successful.

Top module: `tile_win_guard`

## Requirements
- R1: A request in the private window (`PRIV_BASE`, size 2^`SEG_LG2`) is forwarded in the same cycle on the memory port, keeping its direction and write data, at physical address `MEM_BASE` + tile number × 2^`SEG_LG2` + offset.
- R2: The tile number is taken from `tile_id` only while `rst_n` is low. A change of `tile_id` after reset has no effect on relocation until the next reset.
- R3: A read in the global window (`GLOB_BASE`, size `NUM_TILES` × 2^`SEG_LG2`) is forwarded on the memory port at `MEM_BASE` + (address − `GLOB_BASE`). This reaches every tile's segment, this tile's own segment included.
- R4: A write in the global window raises neither `mem_req` nor `per_req`. One cycle later it is answered with `rsp_code` 2'b01 and `rsp_rdata` zero.
- R5: A refused global write sets `viol_flag`, which stays set until reset, and loads the offending address into `viol_addr`. Reads and other accesses leave `viol_addr` unchanged.
- R6: A request in the peripheral window (`PERI_BASE`, size 2^`PERI_LG2`) is forwarded in the same cycle on the peripheral port with the offset inside the window as `per_addr`, whatever the tile number. At most one of `mem_req` and `per_req` is high at a time.
- R7: A request that falls in no window raises neither port request. In the next cycle it is answered with `rsp_code` 2'b10 and `rsp_rdata` zero.
- R8: A forwarded access completes one cycle after its `mem_ack` or `per_ack`, with `rsp_valid` high, `rsp_code` 2'b00 and the returned read data. `rsp_valid` is low in the cycle where the acknowledge arrives.
- R9: When `mem_ecc_err` arrives with `mem_ack`, `sup_ecc_err` pulses for one cycle together with that access's response, and `sup_ecc_addr` holds the physical address of the access. The tile still receives `rsp_code` 2'b00.
- R10: After reset, `rsp_valid`, `viol_flag` and `sup_ecc_err` are low and `viol_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; tile number is captured while low |
| tile_id | input | TID_W | Tile number, sampled during reset |
| cpu_req | input | 1 | Request strobe from the tile bus, one cycle per access |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | AW | Local request address |
| cpu_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 00 ok, 01 write to read-only window, 10 decode error |
| rsp_rdata | output | DW | Read data of the response |
| mem_req | output | 1 | Request to shared main memory |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Physical memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | DW | Memory read data |
| mem_ecc_err | input | 1 | ECC error flag accompanying mem_ack |
| per_req | output | 1 | Request to the tile's peripherals |
| per_we | output | 1 | Peripheral request is a write |
| per_addr | output | AW | Offset inside the peripheral window |
| per_wdata | output | DW | Peripheral write data |
| per_ack | input | 1 | Peripheral completion |
| per_rdata | input | DW | Peripheral read data |
| viol_flag | output | 1 | Sticky: a global-window write was refused |
| viol_addr | output | AW | Address of the latest refused write |
| sup_ecc_err | output | 1 | One-cycle ECC report to the supervisor |
| sup_ecc_addr | output | AW | Physical address of the access that had the ECC error |

## Verification
Forwarded requests appear on the memory or peripheral port in the request cycle itself. The bench samples those ports 1 ns after it drives the request, before the clock edge that consumes the request. Refused and undecoded accesses must show their response at the falling edge just after that clock edge. Forwarded accesses must still show no response at that point; the bench's memory model acknowledges there and expects the response, and any ECC report, at the following falling edge. Checks that something is ignored (a late tile-number change, a read after a refused write) are made through the next forwarded address and through `viol_addr`.

// File: rtl/tile_win_pkg.sv
package tile_win_pkg;

   typedef enum logic [1:0] {
      RSP_OK     = 2'b00,
      RSP_WPROT  = 2'b01,
      RSP_DECERR = 2'b10
   } rsp_code_e;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_MEM   = 2'd1,
      TGT_PERI  = 2'd2,
      TGT_BLOCK = 2'd3
   } tgt_e;

endpackage

// File: rtl/tile_win_idreg.sv
module tile_win_idreg #(
   parameter int TID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TID_W-1:0] tid_in,
   output logic [TID_W-1:0] tid_q
);

   // Tile number loads only while reset is held; frozen afterwards.
   always_ff @(posedge clk) begin
      if (!rst_n) tid_q <= tid_in;
   end

   AST_TID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(tid_q)); // R2

endmodule

// File: rtl/tile_win_decode.sv
module tile_win_decode
   import tile_win_pkg::*;
#(
   parameter int            AW        = 32,
   parameter int            NUM_TILES = 4,
   parameter int            TID_W     = 2,
   parameter int            SEG_LG2   = 16,
   parameter logic [AW-1:0] PRIV_BASE = 32'h1000_0000,
   parameter logic [AW-1:0] GLOB_BASE = 32'h4000_0000,
   parameter logic [AW-1:0] MEM_BASE  = 32'h8000_0000,
   parameter bit            PERI_EN   = 1'b1,
   parameter logic [AW-1:0] PERI_BASE = 32'h2000_0000,
   parameter int            PERI_LG2  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [TID_W-1:0] tid,
   output tgt_e             tgt,
   output logic [AW-1:0]    phys_addr,
   output logic [AW-1:0]    peri_off
);

   localparam int            GLOB_LG2  = SEG_LG2 + TID_W;
   localparam logic [AW-1:0] SEG_MASK  = (AW'(1) << SEG_LG2) - AW'(1);
   localparam logic [AW-1:0] GLOB_MASK = (AW'(1) << GLOB_LG2) - AW'(1);
   localparam logic [AW-1:0] PERI_MASK = (AW'(1) << PERI_LG2) - AW'(1);

   // Elaboration-time parameter checks
   if (GLOB_LG2 >= AW) begin : g_chk_span
      $error("global window does not fit in the address width");
   end
   if ((PRIV_BASE & SEG_MASK) != '0) begin : g_chk_priv
      $error("private window base must be segment aligned");
   end
   if ((GLOB_BASE & GLOB_MASK) != '0) begin : g_chk_glob
      $error("global window base must be aligned to the full span");
   end
   if ((MEM_BASE & GLOB_MASK) != '0) begin : g_chk_mem
      $error("memory base must be aligned to the full span");
   end
   if (NUM_TILES < 1 || NUM_TILES > (1 << TID_W)) begin : g_chk_tiles
      $error("tile count does not fit the tile number width");
   end

   logic             priv_hit;
   logic             glob_hit;
   logic             peri_hit;
   logic             glob_idx_ok;
   logic [TID_W-1:0] glob_idx;

   assign glob_idx = addr[GLOB_LG2-1:SEG_LG2];

   // Segment index bound: trivially true when the tile count fills the field
   if (NUM_TILES == (1 << TID_W)) begin : g_idx_full
      assign glob_idx_ok = 1'b1;
   end else begin : g_idx_part
      assign glob_idx_ok = ({1'b0, glob_idx} < (TID_W+1)'(NUM_TILES));
   end

   // Peripheral window present or absent
   if (PERI_EN) begin : g_peri
      assign peri_hit = ((addr >> PERI_LG2) == (PERI_BASE >> PERI_LG2));
   end else begin : g_no_peri
      assign peri_hit = 1'b0;
   end

   assign priv_hit = ((addr >> SEG_LG2) == (PRIV_BASE >> SEG_LG2));
   assign glob_hit = ((addr >> GLOB_LG2) == (GLOB_BASE >> GLOB_LG2)) && glob_idx_ok;
   assign peri_off = addr & PERI_MASK;

   always_comb begin
      tgt       = TGT_NONE;
      phys_addr = '0;
      if (priv_hit) begin
         tgt       = TGT_MEM;
         phys_addr = MEM_BASE | (AW'(tid) << SEG_LG2) | (addr & SEG_MASK);
      end else if (glob_hit) begin
         tgt       = we ? TGT_BLOCK : TGT_MEM;
         phys_addr = MEM_BASE | (addr & GLOB_MASK);
      end else if (peri_hit) begin
         tgt = TGT_PERI;
      end
   end

   // A write reaching memory may only touch this tile's own segment
   AST_WRITE_OWN_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && tgt == TGT_MEM) |-> (phys_addr[GLOB_LG2-1:SEG_LG2] == tid)); // R4

   // Every forwarded memory address lands inside main memory
   AST_PHYS_IN_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
      (req && tgt == TGT_MEM) |-> ((phys_addr >> GLOB_LG2) == (MEM_BASE >> GLOB_LG2))); // R1

endmodule

// File: rtl/tile_win_rsp.sv
module tile_win_rsp
   import tile_win_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [AW-1:0] addr,
   input  tgt_e          tgt,
   input  logic [AW-1:0] phys_addr,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ecc,
   input  logic          per_ack,
   input  logic [DW-1:0] per_rdata,
   output logic          rsp_valid,
   output logic [1:0]    rsp_code,
   output logic [DW-1:0] rsp_rdata,
   output logic          viol_flag,
   output logic [AW-1:0] viol_addr,
   output logic          sup_ecc,
   output logic [AW-1:0] sup_ecc_addr
);

   rsp_code_e     code_q;
   logic [AW-1:0] mem_pa_q;

   assign rsp_code = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         code_q       <= RSP_OK;
         rsp_rdata    <= '0;
         viol_flag    <= 1'b0;
         viol_addr    <= '0;
         sup_ecc      <= 1'b0;
         sup_ecc_addr <= '0;
         mem_pa_q     <= '0;
      end else begin
         rsp_valid <= 1'b0;
         sup_ecc   <= 1'b0;
         if (req && tgt == TGT_MEM) mem_pa_q <= phys_addr;
         if (req && tgt == TGT_NONE) begin
            rsp_valid <= 1'b1;
            code_q    <= RSP_DECERR;
            rsp_rdata <= '0;
         end else if (req && tgt == TGT_BLOCK) begin
            rsp_valid <= 1'b1;
            code_q    <= RSP_WPROT;
            rsp_rdata <= '0;
            viol_flag <= 1'b1;
            viol_addr <= addr;
         end else if (mem_ack) begin
            rsp_valid <= 1'b1;
            code_q    <= RSP_OK;
            rsp_rdata <= mem_rdata;
            sup_ecc   <= mem_ecc;
            if (mem_ecc) sup_ecc_addr <= mem_pa_q;
         end else if (per_ack) begin
            rsp_valid <= 1'b1;
            code_q    <= RSP_OK;
            rsp_rdata <= per_rdata;
         end
      end
   end

   AST_DECERR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req && tgt == TGT_NONE) |=> (rsp_valid && rsp_code == 2'b10)); // R7

   AST_WPROT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (req && tgt == TGT_BLOCK) |=> (rsp_code == 2'b01 && viol_flag && viol_addr == $past(addr))); // R5

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flag |=> viol_flag); // R5

   AST_ECC_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ack && mem_ecc) |=> (sup_ecc && rsp_valid && rsp_code == 2'b00)); // R9

   AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(req) || $past(mem_ack) || $past(per_ack))); // R8

endmodule

// File: rtl/tile_win_guard.sv
module tile_win_guard
   import tile_win_pkg::*;
#(
   parameter int            AW        = 32,
   parameter int            DW        = 32,
   parameter int            NUM_TILES = 4,
   parameter int            TID_W     = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
   parameter int            SEG_LG2   = 16,
   parameter logic [AW-1:0] PRIV_BASE = 32'h1000_0000,
   parameter logic [AW-1:0] GLOB_BASE = 32'h4000_0000,
   parameter logic [AW-1:0] MEM_BASE  = 32'h8000_0000,
   parameter bit            PERI_EN   = 1'b1,
   parameter logic [AW-1:0] PERI_BASE = 32'h2000_0000,
   parameter int            PERI_LG2  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TID_W-1:0] tile_id,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [AW-1:0]    cpu_addr,
   input  logic [DW-1:0]    cpu_wdata,
   output logic             rsp_valid,
   output logic [1:0]       rsp_code,
   output logic [DW-1:0]    rsp_rdata,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   input  logic             mem_ecc_err,
   output logic             per_req,
   output logic             per_we,
   output logic [AW-1:0]    per_addr,
   output logic [DW-1:0]    per_wdata,
   input  logic             per_ack,
   input  logic [DW-1:0]    per_rdata,
   output logic             viol_flag,
   output logic [AW-1:0]    viol_addr,
   output logic             sup_ecc_err,
   output logic [AW-1:0]    sup_ecc_addr
);

   localparam int GLOB_LG2 = SEG_LG2 + TID_W;

   if (AW < 8 || DW < 1) begin : g_chk_width
      $error("address or data width too small");
   end
   if (PERI_EN && PERI_LG2 >= AW) begin : g_chk_peri
      $error("peripheral window does not fit the address width");
   end

   logic [TID_W-1:0] tid_q;
   tgt_e             tgt;
   logic [AW-1:0]    phys_addr;
   logic [AW-1:0]    peri_off;

   tile_win_idreg #(.TID_W(TID_W)) u_id (
      .clk    (clk),
      .rst_n  (rst_n),
      .tid_in (tile_id),
      .tid_q  (tid_q)
   );

   tile_win_decode #(
      .AW(AW), .NUM_TILES(NUM_TILES), .TID_W(TID_W), .SEG_LG2(SEG_LG2),
      .PRIV_BASE(PRIV_BASE), .GLOB_BASE(GLOB_BASE), .MEM_BASE(MEM_BASE),
      .PERI_EN(PERI_EN), .PERI_BASE(PERI_BASE), .PERI_LG2(PERI_LG2)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (cpu_req),
      .we        (cpu_we),
      .addr      (cpu_addr),
      .tid       (tid_q),
      .tgt       (tgt),
      .phys_addr (phys_addr),
      .peri_off  (peri_off)
   );

   // Forward paths: combinational, same cycle as the request
   assign mem_req   = cpu_req && (tgt == TGT_MEM);
   assign mem_we    = cpu_we;
   assign mem_addr  = phys_addr;
   assign mem_wdata = cpu_wdata;
   assign per_req   = cpu_req && (tgt == TGT_PERI);
   assign per_we    = cpu_we;
   assign per_addr  = peri_off;
   assign per_wdata = cpu_wdata;

   tile_win_rsp #(.AW(AW), .DW(DW)) u_rsp (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (cpu_req),
      .addr         (cpu_addr),
      .tgt          (tgt),
      .phys_addr    (phys_addr),
      .mem_ack      (mem_ack),
      .mem_rdata    (mem_rdata),
      .mem_ecc      (mem_ecc_err),
      .per_ack      (per_ack),
      .per_rdata    (per_rdata),
      .rsp_valid    (rsp_valid),
      .rsp_code     (rsp_code),
      .rsp_rdata    (rsp_rdata),
      .viol_flag    (viol_flag),
      .viol_addr    (viol_addr),
      .sup_ecc      (sup_ecc_err),
      .sup_ecc_addr (sup_ecc_addr)
   );

   AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, per_req})); // R6

   AST_MEM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr >> GLOB_LG2) == (MEM_BASE >> GLOB_LG2))); // R1

   AST_GLOB_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ((cpu_addr >> GLOB_LG2) != (GLOB_BASE >> GLOB_LG2))); // R4

endmodule

// File: tb/tile_win_guard_test.sv
`timescale 1ns/1ps
module tile_win_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  tile_id = 2'd2;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_code;
   logic [31:0] rsp_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0, mem_ecc_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        per_req, per_we;
   logic [31:0] per_addr, per_wdata;
   logic        per_ack = 1'b0;
   logic [31:0] per_rdata = '0;
   logic        viol_flag;
   logic [31:0] viol_addr;
   logic        sup_ecc_err;
   logic [31:0] sup_ecc_addr;

   always #2.5 clk = ~clk;

   tile_win_guard uut (
      .clk(clk), .rst_n(rst_n), .tile_id(tile_id),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_ecc_err(mem_ecc_err),
      .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
      .per_ack(per_ack), .per_rdata(per_rdata),
      .viol_flag(viol_flag), .viol_addr(viol_addr),
      .sup_ecc_err(sup_ecc_err), .sup_ecc_addr(sup_ecc_addr)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Results of the most recent access
   int          t_kind;   // 0 memory, 1 peripheral, 2 none
   logic [31:0] t_fa, t_fwd;
   logic        t_fwe, t_early, t_valid, t_sup;
   logic [1:0]  t_code;
   logic [31:0] t_rdata;

   task automatic do_access(input logic we, input logic [31:0] addr,
                            input logic [31:0] wd, input logic ecc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      #1;
      t_kind = mem_req ? 0 : (per_req ? 1 : 2);
      t_fa   = mem_req ? mem_addr  : (per_req ? per_addr  : 32'h0);
      t_fwe  = mem_req ? mem_we    : (per_req ? per_we    : 1'b0);
      t_fwd  = mem_req ? mem_wdata : (per_req ? per_wdata : 32'h0);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      t_early = rsp_valid;
      t_sup   = 1'b0;
      if (t_kind == 2) begin
         t_valid = rsp_valid; t_code = rsp_code; t_rdata = rsp_rdata;
      end else begin
         if (t_kind == 0) begin
            mem_ack = 1'b1; mem_rdata = t_fa ^ 32'h5A5A_0000; mem_ecc_err = ecc;
         end else begin
            per_ack = 1'b1; per_rdata = t_fa ^ 32'hC0DE_0000;
         end
         @(negedge clk);
         mem_ack = 1'b0; per_ack = 1'b0; mem_ecc_err = 1'b0;
         t_valid = rsp_valid; t_code = rsp_code; t_rdata = rsp_rdata; t_sup = sup_ecc_err;
      end
   endtask

   // {we, addr, kind, expected forwarded address, expected code}
   localparam int NV = 12;
   localparam logic [68:0] VEC [NV] = '{
      {1'b0, 32'h1000_0010, 2'd0, 32'h8002_0010, 2'b00},  // R1 private read
      {1'b1, 32'h1000_FFFC, 2'd0, 32'h8002_FFFC, 2'b00},  // R1 private write, top word
      {1'b0, 32'h4000_0004, 2'd0, 32'h8000_0004, 2'b00},  // R3 global, segment 0
      {1'b0, 32'h4003_1230, 2'd0, 32'h8003_1230, 2'b00},  // R3 global, last segment
      {1'b0, 32'h4002_0010, 2'd0, 32'h8002_0010, 2'b00},  // R3 global, own segment
      {1'b1, 32'h4001_0020, 2'd2, 32'h0000_0000, 2'b01},  // R4 global write refused
      {1'b0, 32'h2000_0ABC, 2'd1, 32'h0000_0ABC, 2'b00},  // R6 peripheral read
      {1'b1, 32'h2000_0004, 2'd1, 32'h0000_0004, 2'b00},  // R6 peripheral write
      {1'b0, 32'h0000_1000, 2'd2, 32'h0000_0000, 2'b10},  // R7 unmapped low
      {1'b1, 32'h2000_1000, 2'd2, 32'h0000_0000, 2'b10},  // R7 just past peripherals
      {1'b0, 32'h1001_0000, 2'd2, 32'h0000_0000, 2'b10},  // R7 just past private
      {1'b0, 32'h4004_0000, 2'd2, 32'h0000_0000, 2'b10}   // R7 just past global
   };

   initial begin : watchdog
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'h0);
      chk("R10 viol_flag", {31'b0, viol_flag}, 32'h0);
      chk("R10 viol_addr", viol_addr, 32'h0);
      chk("R10 sup_ecc_err", {31'b0, sup_ecc_err}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [68:0] v;
         logic [31:0] wd;
         logic [31:0] exp_rd;
         v  = VEC[i];
         wd = 32'hA500_0000 | 32'(i);
         do_access(v[68], v[67:36], wd, 1'b0);
         chk("R1/R3/R4/R6/R7 target", 32'(t_kind), 32'(v[35:34]));
         chk("R1/R3/R6 forwarded address", t_fa, v[33:2]);
         chk("R4/R7/R8 response code", {30'b0, t_code}, {30'b0, v[1:0]});
         chk("R8 response valid", {31'b0, t_valid}, 32'h1);
         chk("R8 response timing", {31'b0, t_early}, (v[35:34] == 2'd2) ? 32'h1 : 32'h0);
         if (v[35:34] == 2'd2) exp_rd = 32'h0;
         else if (v[35:34] == 2'd0) exp_rd = v[33:2] ^ 32'h5A5A_0000;
         else exp_rd = v[33:2] ^ 32'hC0DE_0000;
         chk("R8 read data", t_rdata, exp_rd);
         if (v[35:34] != 2'd2) begin
            chk("R1/R6 direction", {31'b0, t_fwe}, {31'b0, v[68]});
            chk("R1/R6 write data", t_fwd, wd);
         end
      end

      // R5: latched from vector 5, untouched by later reads
      chk("R5 viol_flag", {31'b0, viol_flag}, 32'h1);
      chk("R5 viol_addr kept", viol_addr, 32'h4001_0020);
      do_access(1'b1, 32'h4003_0000, 32'h1, 1'b0);
      chk("R4 top segment write refused", {30'b0, t_code}, 32'h1);
      chk("R5 viol_addr updated", viol_addr, 32'h4003_0000);
      do_access(1'b0, 32'h4000_0100, 32'h0, 1'b0);
      chk("R5 viol_addr after read", viol_addr, 32'h4003_0000);

      // R9: ECC report forwarded, tile response stays ok
      do_access(1'b0, 32'h1000_0040, 32'h0, 1'b1);
      chk("R9 code ok", {30'b0, t_code}, 32'h0);
      chk("R9 sup_ecc pulse", {31'b0, t_sup}, 32'h1);
      chk("R9 sup_ecc_addr", sup_ecc_addr, 32'h8002_0040);
      @(negedge clk);
      chk("R9 pulse ends", {31'b0, sup_ecc_err}, 32'h0);

      // R2: late tile number change ignored
      tile_id = 2'd1;
      do_access(1'b0, 32'h1000_0008, 32'h0, 1'b0);
      chk("R2 id frozen after reset", t_fa, 32'h8002_0008);

      // R2: new reset picks up the new tile number
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 viol_flag after reset", {31'b0, viol_flag}, 32'h0);
      do_access(1'b0, 32'h1000_0008, 32'h0, 1'b0);
      chk("R2 id captured in reset", t_fa, 32'h8001_0008);
      do_access(1'b0, 32'h2000_0ABC, 32'h0, 1'b0);
      chk("R6 peripheral tile-independent", t_fa, 32'h0000_0ABC);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule